// File: doc/BRIEF.md
# Barrel Shifter with Carry Output

This block shifts or rotates a 32-bit data word in one pass and produces the carry flag that the shift would leave behind. A datapath presents the word, a 3-bit operation code, an 8-bit shift count and the current carry flag. The block returns the shifted word and the new carry. Counts of zero, counts equal to the word width and counts beyond the word width each follow their own rule. A one-place rotate moves the incoming carry into the top bit.

A parameter adds an optional output register. With the register present, a transaction marked by `in_valid` appears one clock later with `out_valid` set. The outputs keep their last captured value in cycles with no input. With the register absent, the block is purely combinational and `out_valid` follows `in_valid`.

Top module: `shift_carry_unit`

## Requirements
- R1: Operation code 0 shifts left by n for 1 ≤ n ≤ 32 with zeros entering at bit 0; the carry out is input bit (32−n).
- R2: Operation code 1 shifts right by n for 1 ≤ n ≤ 32 with zeros entering at bit 31; the carry out is input bit (n−1).
- R3: Operation code 2 shifts right by n for 1 ≤ n ≤ 32 with copies of input bit 31 entering at the top; the carry out is input bit (n−1).
- R4: For codes 0 and 1 with a count above 32, the result is all zeros and the carry out is 0.
- R5: For code 2 with a count above 32, every result bit equals input bit 31, and so does the carry out.
- R6: Code 3 rotates right by the count modulo 32 for any nonzero count, and the carry out equals bit 31 of the rotated result. A nonzero multiple of 32 returns the word unchanged, with carry out equal to bit 31.
- R7: Code 4 with a nonzero count moves the word right by exactly one place and puts the incoming carry in bit 31. The carry out is input bit 0. The count value has no further effect.
- R8: A count of zero returns the input word and the incoming carry unchanged, whatever the code.
- R9: Codes 5, 6 and 7 are reserved. They return the input word and the incoming carry unchanged for any count.
- R10: With the output register enabled (default), a transaction with `in_valid` high appears on `result`/`carry_out` one clock later with `out_valid` high. In a cycle after `in_valid` was low, `out_valid` is low and `result`/`carry_out` hold their value.
- R11: A synchronous active-low reset clears `out_valid`, `result` and `carry_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks a transaction on the inputs |
| operand | input | 32 | Data word to shift |
| shift_type | input | 3 | Operation code (0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 one-place rotate through carry) |
| shift_amt | input | 8 | Shift count |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result of a transaction is present |
| result | output | 32 | Shifted word |
| carry_out | output | 1 | Carry produced by the shift |

## Verification
On every cycle, the assertions check these properties:
- the one-cycle latency of the valid flag and the holding of the outputs in idle cycles;
- zero-count pass-through;
- the cleared outputs for logical shifts past the width, and the sign-filled outputs for arithmetic shifts past the width;
- the rotate-through-carry bit placement;
- the tie between the rotate carry and the result's top bit.

The exact bit selected as carry for in-range shifts, the modulo wrap of rotate counts and the reserved codes are covered only by the bench's scenarios. Those scenarios sweep every code against counts 0, 1, 7, 31, 32, 33, 64 and 255, add random transactions with idle gaps, and apply a reset mid-run.

// File: rtl/shc_pkg.sv
// Shared types for the shifter.
// Assumes: operation codes are three bits wide; codes above 4 are reserved.
package shc_pkg;

    typedef enum logic [2:0] {
        SHT_LSL = 3'd0,
        SHT_LSR = 3'd1,
        SHT_ASR = 3'd2,
        SHT_ROR = 3'd3,
        SHT_RRX = 3'd4
    } shift_kind_e;

    // Classification of the shift count relative to the word width
    typedef struct packed {
        logic is_zero;
        logic over;
    } amt_class_t;

endpackage

// File: rtl/shc_amount_class.sv
// Sorts the shift count into zero / in range / beyond width and derives
// a clamped count and a rotate index.
// Assumes: DATA_W is a power of two and AMT_W > $clog2(DATA_W).
module shc_amount_class
    import shc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [AMT_W-1:0] amt,
    output amt_class_t       cls,
    output logic [IDX_W:0]   clamp,
    output logic [IDX_W-1:0] rot
);

    localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(DATA_W);
    localparam logic [IDX_W:0]   CLAMP_MAX = (IDX_W + 1)'(DATA_W);

    // Classify the count and clamp it to the word width
    always_comb begin
        cls.is_zero = (amt == '0);
        cls.over    = (amt > AMT_FULL);
        clamp       = cls.over ? CLAMP_MAX : amt[IDX_W:0];
        rot         = amt[IDX_W-1:0];
    end

endmodule

// File: rtl/shc_core.sv
// Combinational shift/rotate datapath with carry generation.
// Assumes: clamp never exceeds DATA_W; rot is the count modulo DATA_W.
module shc_core
    import shc_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [2:0]        kind,
    input  amt_class_t        cls,
    input  logic [IDX_W:0]    clamp,
    input  logic [IDX_W-1:0]  rot,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              cout
);

    logic [DATA_W:0]          lsl_ext;
    logic [DATA_W:0]          lsr_ext;
    logic signed [DATA_W:0]   asr_ext;
    logic [2*DATA_W-1:0]      ror_dbl;
    logic [DATA_W-1:0]        ror_res;

    // Extended shifters: the extra bit captures the last bit shifted out
    always_comb begin
        lsl_ext = {1'b0, operand} << clamp;
        lsr_ext = {operand, 1'b0} >> clamp;
        asr_ext = $signed({operand, 1'b0}) >>> clamp;
        ror_dbl = {operand, operand} >> rot;
        ror_res = ror_dbl[DATA_W-1:0];
    end

    // Select the result and carry per operation code and count class
    always_comb begin
        res  = operand;
        cout = carry_in;
        if (!cls.is_zero) begin
            case (kind)
                SHT_LSL: begin
                    res  = cls.over ? '0   : lsl_ext[DATA_W-1:0];
                    cout = cls.over ? 1'b0 : lsl_ext[DATA_W];
                end
                SHT_LSR: begin
                    res  = cls.over ? '0   : lsr_ext[DATA_W:1];
                    cout = cls.over ? 1'b0 : lsr_ext[0];
                end
                SHT_ASR: begin
                    res  = asr_ext[DATA_W:1];
                    cout = asr_ext[0];
                end
                SHT_ROR: begin
                    res  = ror_res;
                    cout = ror_res[DATA_W-1];
                end
                SHT_RRX: begin
                    res  = {carry_in, operand[DATA_W-1:1]};
                    cout = operand[0];
                end
                default: begin
                    res  = operand;
                    cout = carry_in;
                end
            endcase
        end
    end

endmodule

// File: rtl/shc_out_stage.sv
// Optional output register: captures on valid input, holds otherwise.
// Assumes: with REG_OUT = 0 the stage is a wire and clk/rst_n are unused.
module shc_out_stage #(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] d_res,
    input  logic              d_c,
    output logic              out_valid,
    output logic [DATA_W-1:0] q_res,
    output logic              q_c
);

    if (REG_OUT) begin : g_reg
        // Delay valid by one cycle
        always_ff @(posedge clk) begin
            if (!rst_n) out_valid <= 1'b0;
            else        out_valid <= in_valid;
        end

        // Capture result and carry only for a valid transaction
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_res <= '0;
                q_c   <= 1'b0;
            end else if (in_valid) begin
                q_res <= d_res;
                q_c   <= d_c;
            end
        end

        AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R10
        AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid); // R10
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(q_res) && $stable(q_c))); // R10
    end else begin : g_comb
        assign out_valid = in_valid;
        assign q_res     = d_res;
        assign q_c       = d_c;
    end

endmodule

// File: rtl/shift_carry_unit.sv
// Top of the shifter: count classification, datapath and output stage.
// Assumes: inputs are stable around the clock edge when in_valid is high.
module shift_carry_unit
    import shc_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int AMT_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic [2:0]        shift_type,
    input  logic [AMT_W-1:0]  shift_amt,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);

    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [AMT_W-1:0] AMT_FULL = AMT_W'(DATA_W);

    amt_class_t        amt_cls;
    logic [IDX_W:0]    amt_clamp;
    logic [IDX_W-1:0]  amt_rot;
    logic [DATA_W-1:0] core_res;
    logic              core_c;

    shc_amount_class #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_class (
        .amt   (shift_amt),
        .cls   (amt_cls),
        .clamp (amt_clamp),
        .rot   (amt_rot)
    );

    shc_core #(.DATA_W(DATA_W)) i_core (
        .operand  (operand),
        .kind     (shift_type),
        .cls      (amt_cls),
        .clamp    (amt_clamp),
        .rot      (amt_rot),
        .carry_in (carry_in),
        .res      (core_res),
        .cout     (core_c)
    );

    shc_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d_res     (core_res),
        .d_c       (core_c),
        .out_valid (out_valid),
        .q_res     (result),
        .q_c       (carry_out)
    );

    if (REG_OUT) begin : g_chk
        AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && shift_amt == '0) |=>
            (result == $past(operand) && carry_out == $past(carry_in))); // R8
        AST_LOGIC_OVER: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && shift_type inside {3'd0, 3'd1} && shift_amt > AMT_FULL) |=>
            (result == '0 && !carry_out)); // R4
        AST_ASR_OVER: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && shift_type == 3'd2 && shift_amt > AMT_FULL) |=>
            (result == {DATA_W{$past(operand[DATA_W-1])}} &&
             carry_out == $past(operand[DATA_W-1]))); // R5
        AST_ROR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && shift_type == 3'd3 && shift_amt != '0) |=>
            (carry_out == result[DATA_W-1])); // R6
        AST_RRX_BITS: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && shift_type == 3'd4 && shift_amt != '0) |=>
            (result == {$past(carry_in), $past(operand[DATA_W-1:1])} &&
             carry_out == $past(operand[0]))); // R7
    end

endmodule

// File: tb/test_shift_carry_unit.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and compares.
module test_shift_carry_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] operand;
    logic [2:0]  shift_type;
    logic [7:0]  shift_amt;
    logic        carry_in;
    logic        out_valid;
    logic [31:0] result;
    logic        carry_out;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [31:0] res;
        logic        c;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    exp_t        last;
    bit          have_last = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_carry_unit i_shift_carry_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .shift_type(shift_type), .shift_amt(shift_amt), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .carry_out(carry_out)
    );

    // Bit-serial reference model written from the requirements
    function automatic void model(input logic [31:0] op, input logic [2:0] t,
                                  input int amt, input logic cin,
                                  output logic [31:0] r, output logic c);
        r = op;
        c = cin;
        if (amt == 0 || t > 3'd4) return;
        case (t)
            3'd0: if (amt > 32) begin r = '0; c = 1'b0; end
                  else for (int i = 0; i < amt; i++) begin c = r[31]; r = r << 1; end
            3'd1: if (amt > 32) begin r = '0; c = 1'b0; end
                  else for (int i = 0; i < amt; i++) begin c = r[0]; r = r >> 1; end
            3'd2: for (int i = 0; i < ((amt > 32) ? 32 : amt); i++) begin
                      c = r[0]; r = {r[31], r[31:1]};
                  end
            3'd3: begin
                      for (int i = 0; i < (amt % 32); i++) r = {r[0], r[31:1]};
                      c = r[31];
                  end
            default: begin c = op[0]; r = {cin, op[31:1]}; end
        endcase
    endfunction

    function automatic string req_tag(input logic [2:0] t, input int amt);
        if (amt == 0) return "R8";
        if (t > 3'd4) return "R9";
        case (t)
            3'd0: return (amt > 32) ? "R4" : "R1";
            3'd1: return (amt > 32) ? "R4" : "R2";
            3'd2: return (amt > 32) ? "R5" : "R3";
            3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [32:0] act, input logic [32:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one transaction and push its expected outcome
    task automatic drive(input logic [31:0] op, input logic [2:0] t,
                         input logic [7:0] amt, input logic cin);
        exp_t e;
        @(negedge clk);
        in_valid   = 1'b1;
        operand    = op;
        shift_type = t;
        shift_amt  = amt;
        carry_in   = cin;
        model(op, t, int'(amt), cin, e.res, e.c);
        e.tag = req_tag(t, int'(amt));
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            operand   = $urandom;
            carry_in  = ~carry_in;
        end
    endtask

    // Monitor: compare outputs against the scoreboard away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            have_last = 0;
        end else if (out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10", "unexpected out_valid", 33'd1, 33'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({carry_out, result} == {e.c, e.res}, e.tag, "carry,result",
                      {carry_out, result}, {e.c, e.res});
                last = e;
                have_last = 1;
            end
        end else if (have_last) begin
            // R10: outputs hold in a cycle after no valid input
            check({carry_out, result} == {last.c, last.res}, "R10", "hold",
                  {carry_out, result}, {last.c, last.res});
        end
    end

    task automatic check_reset_state();
        check(out_valid == 1'b0, "R11", "out_valid", {32'd0, out_valid}, 33'd0);
        check({carry_out, result} == 33'd0, "R11", "carry,result",
              {carry_out, result}, 33'd0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  amts [8] = '{8'd0, 8'd1, 8'd7, 8'd31, 8'd32, 8'd33, 8'd64, 8'd255};
        logic [31:0] ops  [2] = '{32'h8000_0001, 32'h7ACE_5321};
        rst_n = 1'b0; in_valid = 1'b0; operand = 32'hFFFF_FFFF;
        shift_type = 3'd0; shift_amt = 8'd5; carry_in = 1'b1;
        repeat (3) @(negedge clk);
        check_reset_state(); // R11
        rst_n = 1'b1;
        idle(2);
        check(out_valid == 1'b0, "R10", "no valid after idle", {32'd0, out_valid}, 33'd0);

        // Directed sweep over every code and boundary count
        for (int t = 0; t < 8; t++)
            for (int a = 0; a < 8; a++)
                for (int o = 0; o < 2; o++)
                    drive(ops[o], 3'(t), amts[a], 1'(o ^ a));
        idle(3);

        // Random traffic with idle gaps
        for (int k = 0; k < 400; k++) begin
            drive($urandom, 3'($urandom % 8), 8'($urandom), 1'($urandom));
            if ($urandom % 4 == 0) idle(1 + $urandom % 3);
        end
        idle(3);
        check(sb.size() == 0, "R10", "missing results", 33'(sb.size()), 33'd0);

        // Mid-run reset after activity
        drive(32'hDEAD_BEEF, 3'd3, 8'd8, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state(); // R11
        sb.delete();
        rst_n = 1'b1;
        idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule